// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block is a single-channel DMA engine. It copies a programmed number of words between one peripheral and a synchronous memory port, and the processor does not touch the data. Software loads a start address, a word count and a direction bit through a small write-only configuration port. A service request from the peripheral then makes the engine ask the processor for the system bus with a hold request.

The engine drives nothing onto the bus until the processor answers with a hold acknowledge, which it sends after finishing its current cycle. The engine then acknowledges the peripheral and moves one word per clock. Each word advances the address and reduces the remaining count. When the count is used up, the engine withdraws its hold request and returns the bus. It also sets a sticky terminal-count flag and fires a one-cycle done pulse.

If the peripheral withdraws its request part way through, the engine gives the bus back. It re-arbitrates when the request returns and continues from the address and count where it stopped.

Top module: `cs_dma`

## Requirements
- R1: After reset, hold_req, per_ack, mem_en, per_wvalid, tc_flag and done_irq are all 0. The working address, the count and the direction are all 0.
- R2: A write with cfg_we=1 loads a register selected by cfg_sel: 0 loads the address, 1 loads the count (the low CNT_W bits), and 2 loads the direction from cfg_wdata[0], where 0 means peripheral-to-memory and 1 means memory-to-peripheral. While the count is 0, per_req is ignored and hold_req stays 0.
- R3: While the engine is idle with a nonzero count, per_req=1 raises hold_req on the next clock edge.
- R4: While hold_ack is 0 after a request, per_ack and mem_en stay 0. per_ack rises only after a cycle in which hold_ack was 1.
- R5: Peripheral-to-memory: each cycle with mem_en=1 has mem_we=1 and writes per_rdata to mem_addr. The address then steps up by one and the count down by one, so words land at consecutive addresses starting at the programmed address.
- R6: Memory-to-peripheral: each cycle with mem_en=1 has mem_we=0. The read word appears on per_wdata with per_wvalid=1 in the next cycle, in address order, and memory is not written.
- R7: After the last word, hold_req returns to 0, tc_flag becomes 1, and done_irq is 1 for exactly one cycle. During that cycle hold_req is 0.
- R8: If per_req falls while the count is nonzero, the engine moves no further words and releases hold_req without setting tc_flag or pulsing done_irq. When per_req returns, it requests the bus again and finishes the remaining words at the following addresses.
- R9: A count write clears tc_flag on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 direction |
| cfg_wdata | input | ADDR_W | Configuration write data |
| tc_flag | output | 1 | Sticky terminal-count flag |
| done_irq | output | 1 | One-cycle completion pulse |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Peripheral acknowledge (engine owns the bus) |
| per_rdata | input | DATA_W | Word from peripheral (peripheral-to-memory) |
| per_wdata | output | DATA_W | Word to peripheral (memory-to-peripheral) |
| per_wvalid | output | 1 | per_wdata holds a fresh word |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Bus hold acknowledge from the processor |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after a read |

## Verification
The assertions assume that the processor keeps hold_ack high for as long as hold_req stays high once it has granted. They also assume that memory returns read data exactly one cycle after the strobe, and that software does not reprogram the engine while it holds the bus. The bench's processor model derives hold_ack from hold_req with a one-cycle lag, gated by a grant enable, and withdraws it only after hold_req falls. Its memory model registers read data on the strobe edge. Every configuration write is made while the engine is idle.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_MOVE  = 2'd2,
      ST_DRAIN = 2'd3
   } dma_st_t;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_CNT  = 2'd1;
   localparam logic [1:0] SEL_DIR  = 2'd2;

endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
   import cs_dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              step,
   input  logic              set_tc,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_cnt,
   output logic              dir_m2p,
   output logic              tc_flag
);

   localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0]  C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_load;
   logic             wr_addr, wr_cnt, wr_dir;

   generate
      if (CNT_W == ADDR_W) begin : g_cnt_full
         assign cnt_load = cfg_wdata;
      end else begin : g_cnt_slice
         assign cnt_load = cfg_wdata[CNT_W-1:0];
      end
   endgenerate

   assign wr_addr = cfg_we && (cfg_sel == SEL_ADDR);
   assign wr_cnt  = cfg_we && (cfg_sel == SEL_CNT);
   assign wr_dir  = cfg_we && (cfg_sel == SEL_DIR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         cur_cnt  <= '0;
         dir_m2p  <= 1'b0;
         tc_flag  <= 1'b0;
      end else begin
         if (wr_addr)   cur_addr <= cfg_wdata;
         else if (step) cur_addr <= cur_addr + A_ONE;

         if (wr_cnt)    cur_cnt <= cnt_load;
         else if (step) cur_cnt <= cur_cnt - C_ONE;

         if (wr_dir)    dir_m2p <= cfg_wdata[0];

         if (wr_cnt)      tc_flag <= 1'b0;
         else if (set_tc) tc_flag <= 1'b1;
      end
   end

   // R5
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cfg_we) |=> (cur_addr == $past(cur_addr) + A_ONE) && (cur_cnt == $past(cur_cnt) - C_ONE));

   // R9
   tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> !tc_flag);

endmodule

// File: rtl/cs_dma_ctl.sv
module cs_dma_ctl
   import cs_dma_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             per_req,
   input  logic             hold_ack,
   input  logic [CNT_W-1:0] cur_cnt,
   input  logic             dir_m2p,
   output logic             hold_req,
   output logic             per_ack,
   output logic             issue,
   output logic             issue_wr,
   output logic             rd_pend,
   output logic             set_tc,
   output logic             done_irq
);

   localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   dma_st_t st, st_nx;
   logic    cnt_zero, last_word;

   assign cnt_zero  = (cur_cnt == '0);
   assign issue     = (st == ST_MOVE) && per_req && hold_ack && !cnt_zero;
   assign issue_wr  = issue && !dir_m2p;
   assign last_word = issue && (cur_cnt == C_ONE);
   assign set_tc    = (st == ST_DRAIN) && cnt_zero;
   assign hold_req  = (st != ST_IDLE);
   assign per_ack   = (st == ST_MOVE);

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE:  if (per_req && !cnt_zero) st_nx = ST_WAIT;
         ST_WAIT:  if (hold_ack) st_nx = ST_MOVE;
         ST_MOVE:  if (last_word || !per_req) st_nx = ST_DRAIN;
         ST_DRAIN: st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         rd_pend  <= 1'b0;
         done_irq <= 1'b0;
      end else begin
         st       <= st_nx;
         rd_pend  <= issue && dir_m2p;
         done_irq <= set_tc;
      end
   end

   // R4
   grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(per_ack) |-> $past(hold_ack));

   // R2
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && cnt_zero) |=> !hold_req);

   // R6
   rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pend |-> $past(issue && !issue_wr));

   // R7
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);

   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> !hold_req);

endmodule

// File: rtl/cs_dma.sv
module cs_dma
   import cs_dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic              tc_flag,
   output logic              done_irq,
   input  logic              per_req,
   output logic              per_ack,
   input  logic [DATA_W-1:0] per_rdata,
   output logic [DATA_W-1:0] per_wdata,
   output logic              per_wvalid,
   output logic              hold_req,
   input  logic              hold_ack,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt
         $error("cs_dma: CNT_W must lie in 1..ADDR_W");
      end
      if (DATA_W < 1 || ADDR_W < 2) begin : g_bad_width
         $error("cs_dma: DATA_W must be >= 1 and ADDR_W >= 2");
      end
   endgenerate

   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  cur_cnt;
   logic              dir_m2p, issue, issue_wr, rd_pend, set_tc;

   cs_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .step      (issue),
      .set_tc    (set_tc),
      .cur_addr  (cur_addr),
      .cur_cnt   (cur_cnt),
      .dir_m2p   (dir_m2p),
      .tc_flag   (tc_flag)
   );

   cs_dma_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .per_req   (per_req),
      .hold_ack  (hold_ack),
      .cur_cnt   (cur_cnt),
      .dir_m2p   (dir_m2p),
      .hold_req  (hold_req),
      .per_ack   (per_ack),
      .issue     (issue),
      .issue_wr  (issue_wr),
      .rd_pend   (rd_pend),
      .set_tc    (set_tc),
      .done_irq  (done_irq)
   );

   assign mem_en     = issue;
   assign mem_we     = issue_wr;
   assign mem_addr   = cur_addr;
   assign mem_wdata  = per_rdata;
   assign per_wdata  = mem_rdata;
   assign per_wvalid = rd_pend;

   // R4
   bus_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (hold_req && per_ack));

endmodule

// File: tb/sim_cs_dma.sv
`timescale 1ns/1ps
module sim_cs_dma;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_wdata = 16'd0;
   logic        tc_flag, done_irq, per_ack, per_wvalid, hold_req;
   logic        per_req = 1'b0;
   logic        hold_ack = 1'b0;
   logic [15:0] per_rdata, per_wdata;
   logic        mem_en, mem_we;
   logic [15:0] mem_addr, mem_wdata;
   logic [15:0] mem_rdata = 16'd0;

   logic [15:0] mem [0:255];
   logic [15:0] plog [0:15];
   int          lcnt = 0;
   int          pidx = 0;
   logic [15:0] pbase = 16'h0;
   logic        grant_en = 1'b0;
   int          n_chk = 0, n_bad = 0;
   bit          fin = 1'b0;

   always #2 clk = ~clk;

   cs_dma u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .tc_flag(tc_flag), .done_irq(done_irq), .per_req(per_req), .per_ack(per_ack),
      .per_rdata(per_rdata), .per_wdata(per_wdata), .per_wvalid(per_wvalid),
      .hold_req(hold_req), .hold_ack(hold_ack), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   assign per_rdata = pbase + 16'(pidx);

   always @(posedge clk) begin
      hold_ack <= rst_n && hold_req && grant_en;
      if (mem_en && mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         pidx <= pidx + 1;
      end
      if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
      if (per_wvalid && lcnt < 16) begin
         plog[lcnt] <= per_wdata;
         lcnt <= lcnt + 1;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // run n cycles, counting done pulses and checking release at the pulse
   task automatic run_count(input int n, output int irqs);
      irqs = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (done_irq) begin
            irqs++;
            chk("R7 hold_req low during done pulse", hold_req, 0);
            chk("R7 tc_flag set at done pulse", tc_flag, 1);
         end
      end
   endtask

   task automatic t_reset;
      chk("R1 hold_req", hold_req, 0);
      chk("R1 per_ack", per_ack, 0);
      chk("R1 mem_en", mem_en, 0);
      chk("R1 per_wvalid", per_wvalid, 0);
      chk("R1 tc_flag", tc_flag, 0);
      chk("R1 done_irq", done_irq, 0);
   endtask

   task automatic t_zero_count;
      int seen = 0;
      per_req = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (hold_req) seen++;
      end
      per_req = 1'b0;
      chk("R2 request ignored with count 0", seen, 0);
   endtask

   task automatic t_p2m;
      int irqs, bad_wait;
      for (int i = 0; i < 8; i++) mem[16'h10 + i] = 16'hEEEE;
      pbase = 16'hA0; pidx = 0; grant_en = 1'b0;
      wr_cfg(2'd0, 16'h0010);
      wr_cfg(2'd2, 16'h0000);
      wr_cfg(2'd1, 16'h0006);
      per_req = 1'b1;
      @(negedge clk);
      chk("R3 hold_req after per_req", hold_req, 1);
      bad_wait = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (per_ack || mem_en) bad_wait++;
      end
      chk("R4 no bus activity before hold_ack", bad_wait, 0);
      grant_en = 1'b1;
      run_count(30, irqs);
      per_req = 1'b0;
      chk("R7 one done pulse", irqs, 1);
      chk("R7 hold_req released", hold_req, 0);
      chk("R7 tc_flag sticky", tc_flag, 1);
      for (int i = 0; i < 6; i++)
         chk($sformatf("R5 word %0d at consecutive address", i), mem[16'h10 + i], 16'hA0 + i);
      chk("R5 word past count untouched", mem[16'h16], 16'hEEEE);
   endtask

   task automatic t_clear_tc;
      wr_cfg(2'd1, 16'h0003);
      chk("R9 count write clears tc_flag", tc_flag, 0);
   endtask

   task automatic t_m2p;
      int irqs;
      for (int i = 0; i < 3; i++) mem[16'h40 + i] = 16'h5000 + 16'(i * 3);
      lcnt = 0;
      wr_cfg(2'd0, 16'h0040);
      wr_cfg(2'd2, 16'h0001);
      wr_cfg(2'd1, 16'h0003);
      per_req = 1'b1;
      run_count(25, irqs);
      per_req = 1'b0;
      chk("R6 words delivered", lcnt, 3);
      for (int i = 0; i < 3; i++)
         chk($sformatf("R6 word %0d in order", i), plog[i], 16'h5000 + i * 3);
      chk("R6 memory not written", mem[16'h40], 16'h5000);
      chk("R7 done pulse after read transfer", irqs, 1);
   endtask

   task automatic t_pause;
      int irqs, held, paused, moved;
      for (int i = 0; i < 9; i++) mem[16'h80 + i] = 16'hEEEE;
      pbase = 16'hC0; pidx = 0;
      wr_cfg(2'd0, 16'h0080);
      wr_cfg(2'd2, 16'h0000);
      wr_cfg(2'd1, 16'h0008);
      per_req = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (pidx >= 3) break;
      end
      per_req = 1'b0;
      paused = pidx;
      held = 0; irqs = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (done_irq) irqs++;
         if (i >= 3 && hold_req) held++;
      end
      moved = pidx - paused;
      chk("R8 hold_req released on pause", held, 0);
      chk("R8 no words while paused", moved, 0);
      chk("R8 no done pulse on pause", irqs, 0);
      chk("R8 tc_flag clear on pause", tc_flag, 0);
      per_req = 1'b1;
      run_count(40, irqs);
      per_req = 1'b0;
      chk("R8 resumed transfer completes", irqs, 1);
      chk("R8 total words moved", pidx, 8);
      for (int i = 0; i < 8; i++)
         chk($sformatf("R8 word %0d after resume", i), mem[16'h80 + i], 16'hC0 + i);
      chk("R8 word past count untouched", mem[16'h88], 16'hEEEE);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_zero_count;
      t_p2m;
      t_clear_tc;
      t_m2p;
      t_pause;
      fin = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule